// File: doc/BRIEF.md
# Multi-Size Subword SIMD Arithmetic Unit

This block is a pipelined arithmetic unit that applies one operation to every packed subword of two operand words at the same time. The subword (lane) width is picked on each issue from 8, 10, 12 or 16 bits. The same carry chain serves every width: its carries are cut at the lane edges that the selected width defines. The widths need not be multiples of one another, so 10- and 12-bit pixel samples pack without being widened to 16 bits.

The unit offers five operations: lane-wise add, lane-wise absolute difference, lane-wise multiply, a sum of absolute differences that is also reduced to one scalar, and a lane-wise multiply-accumulate into a bank of double-width accumulators. Every issue carries its own width and opcode. A change of either applies to that issue and costs no extra cycle. A new operation can be accepted on every clock, and its result appears a fixed two cycles later. With the default 48-bit word there are 6 lanes of 8 bits, 4 of 10 bits (top 8 bits unused), 4 of 12 bits, or 3 of 16 bits.

Top module: `simd_subword_unit`

## Requirements
- R1: While reset is low at a rising edge, the next values of out_valid_o, result_o, scalar_o and acc_o are all zero.
- R2: An operation sampled with in_valid_i high at edge N raises out_valid_o after edge N+1. Operations may be issued on every cycle. When no result is due, out_valid_o is low and result_o/scalar_o keep their last values.
- R3: Width code mode_i: 0=8, 1=10, 2=12, 3=16 bits. Lane k occupies bits [k*s +: s] of a packed word. Opcode 0 (add) gives each lane (a+b) mod 2^s, and no carry passes between lanes.
- R4: Opcode 1 (absolute difference) gives |a-b| per lane, treating both operands as unsigned.
- R5: Opcode 2 (multiply) gives the low s bits of the unsigned product in each lane.
- R6: Opcode 3 (SAD) puts the lane absolute differences on result_o. It also puts their unsigned sum on scalar_o, which is 16+clog2(WORD_W/8) bits wide (19 by default) so that it cannot overflow.
- R7: Opcode 4 (multiply-accumulate) adds the full unsigned lane product, modulo 2^(2s), to accumulator lane k held at acc_o bits [k*2s +: 2s]. It returns the low s bits of each updated accumulator lane on result_o. Accumulator bits above the last lane are left unchanged.
- R8: acc_clr_i high at a rising edge zeroes acc_o at that edge. The clear takes priority over a multiply-accumulate completing at the same edge.
- R9: Successive issues may change width and opcode on every cycle, and each result follows only its own issue's width and opcode.
- R10: scalar_o is zero for every opcode except SAD. Opcodes 5 to 7 give a zero result and leave the accumulator unchanged.
- R11: Operand bits above the last lane (bits 47:40 at width 10) are ignored, and result bits above the last lane are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid_i | input | 1 | Issue strobe for the operands and controls below |
| mode_i | input | 2 | Lane width code (0=8, 1=10, 2=12, 3=16) |
| op_i | input | 3 | Opcode (0 add, 1 absdiff, 2 mul, 3 SAD, 4 MAC) |
| opa_i | input | WORD_W | Packed operand A |
| opb_i | input | WORD_W | Packed operand B |
| acc_clr_i | input | 1 | Zeroes the accumulator bank at this edge |
| out_valid_o | output | 1 | Result strobe |
| result_o | output | WORD_W | Packed lane results |
| scalar_o | output | 16+clog2(WORD_W/8) | SAD reduction result |
| acc_o | output | 2*WORD_W | Packed accumulator lanes |

## Verification
An issue sampled at one rising edge has its result, its SAD scalar and its accumulator update visible after the second rising edge. A clear shows on acc_o after the very edge that sampled it. The bench model keeps the same two-stage delay and applies the clear at the edge it samples. All outputs are compared with the model at every falling edge, so each value is read one half-cycle after the edge that produced it. The checker tests the same two-edge spacing with a warm-up counter, so that none of its history reaches back into reset.

// File: rtl/simd_pkg.sv
// Shared width codes, opcodes and lane-width decode for the subword unit.
package simd_pkg;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_10 = 2'd1,
        SZ_12 = 2'd2,
        SZ_16 = 2'd3
    } size_e;

    typedef enum logic [2:0] {
        OP_ADD     = 3'd0,
        OP_ABSDIFF = 3'd1,
        OP_MUL     = 3'd2,
        OP_SAD     = 3'd3,
        OP_MAC     = 3'd4
    } op_e;

    // Lane width in bits for a width code.
    function automatic int lane_bits(input size_e m);
        case (m)
            SZ_8:    return 8;
            SZ_10:   return 10;
            SZ_12:   return 12;
            default: return 16;
        endcase
    endfunction

endpackage

// File: rtl/simd_seg_adder.sv
// Segmented ripple adder: one carry chain whose carry is reloaded with cin
// at the first bit of every lane. Lane width = lane_bits(mode) * SCALE.
// Assumes W holds at least one lane of the widest size. Bits above the last
// whole lane give zero sum. lane_co repeats each lane's carry-out on all
// of that lane's bits.
module simd_seg_adder
    import simd_pkg::*;
#(
    parameter int W     = 48,
    parameter int SCALE = 1
) (
    input  size_e          mode,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cin,
    output logic [W-1:0]   sum,
    output logic [W-1:0]   lane_co
);

    int           lane_w;
    int           used_w;
    logic [W-1:0] co_bit;

    assign lane_w = lane_bits(mode) * SCALE;
    assign used_w = (W / lane_w) * lane_w;

    // Carry chain with a cut at every lane start.
    always_comb begin
        logic c;
        c      = 1'b0;
        sum    = '0;
        co_bit = '0;
        for (int i = 0; i < W; i++) begin
            if (i % lane_w == 0) c = cin;
            sum[i]    = (i < used_w) ? (a[i] ^ b[i] ^ c) : 1'b0;
            co_bit[i] = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
            c         = co_bit[i];
        end
    end

    // Spread each lane's top carry across the lane.
    always_comb begin
        logic sel;
        sel     = 1'b0;
        lane_co = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (i % lane_w == lane_w - 1) sel = co_bit[i];
            lane_co[i] = (i < used_w) ? sel : 1'b0;
        end
    end

endmodule

// File: rtl/simd_lane_absdiff.sv
// Lane-wise unsigned |a-b| on the segmented chain. a-b and b-a are formed
// in parallel and each lane picks the one that did not borrow.
// Assumes the same lane layout as simd_seg_adder.
module simd_lane_absdiff
    import simd_pkg::*;
#(
    parameter int W = 48
) (
    input  size_e        mode,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] diff
);

    logic [W-1:0] d_ab, d_ba, co_ab, ba_co_unused;

    simd_seg_adder #(.W(W), .SCALE(1)) u_ab (
        .mode(mode), .a(a), .b(~b), .cin(1'b1), .sum(d_ab), .lane_co(co_ab)
    );

    simd_seg_adder #(.W(W), .SCALE(1)) u_ba (
        .mode(mode), .a(b), .b(~a), .cin(1'b1), .sum(d_ba), .lane_co(ba_co_unused)
    );

    // Per bit, keep a-b where that lane had no borrow (a >= b).
    always_comb begin
        for (int i = 0; i < W; i++) diff[i] = co_ab[i] ? d_ab[i] : d_ba[i];
    end

endmodule

// File: rtl/simd_lane_mul.sv
// Lane-wise unsigned multiply. One bank of full products per width, packed
// at double-width spacing (lane k at [k*2s +: 2s]); the width code picks
// the bank. Bits above the last lane are zero.
module simd_lane_mul
    import simd_pkg::*;
#(
    parameter int W = 48
) (
    input  size_e            mode,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    output logic [2*W-1:0]   prod
);

    localparam int NSIZES = 4;

    logic [2*W-1:0] p_all [NSIZES];

    for (genvar k = 0; k < NSIZES; k++) begin : g_size
        localparam int S  = (k == 3) ? 16 : 8 + 2 * k;
        localparam int NL = W / S;
        localparam int P  = 2 * S;
        logic [2*W-1:0] pk;
        for (genvar l = 0; l < NL; l++) begin : g_lane
            assign pk[l*P +: P] = P'(a[l*S +: S]) * P'(b[l*S +: S]);
        end
        if (NL * P < 2 * W) begin : g_pad
            assign pk[2*W-1:NL*P] = '0;
        end
        assign p_all[k] = pk;
    end

    // Select the bank for the issued width.
    always_comb begin
        case (mode)
            SZ_8:    prod = p_all[0];
            SZ_10:   prod = p_all[1];
            SZ_12:   prod = p_all[2];
            default: prod = p_all[3];
        endcase
    end

endmodule

// File: rtl/simd_subword_unit.sv
// Multi-size subword SIMD unit. Stage 1 registers the issue; stage 2
// computes from those registers and registers result, scalar and the
// accumulator bank. Latency 2, one issue per cycle. Assumes WORD_W holds
// at least one 16-bit lane. Reset is synchronous and active low.
module simd_subword_unit
    import simd_pkg::*;
#(
    parameter  int WORD_W = 48,
    localparam int SUM_W  = 16 + $clog2(WORD_W / 8),
    localparam int ACC_W  = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid_i,
    input  logic [1:0]        mode_i,
    input  logic [2:0]        op_i,
    input  logic [WORD_W-1:0] opa_i,
    input  logic [WORD_W-1:0] opb_i,
    input  logic              acc_clr_i,
    output logic              out_valid_o,
    output logic [WORD_W-1:0] result_o,
    output logic [SUM_W-1:0]  scalar_o,
    output logic [ACC_W-1:0]  acc_o
);

    // Repack double-width lanes to their low s bits at single spacing.
    function automatic logic [WORD_W-1:0] narrow(input logic [ACC_W-1:0] wide, input int s);
        logic [WORD_W-1:0] r;
        r = '0;
        for (int i = 0; i < WORD_W; i++)
            if (i < (WORD_W / s) * s) r[i] = wide[(i / s) * 2 * s + i % s];
        return r;
    endfunction

    // Sum of all lanes of a packed word, each bit weighted by its lane offset.
    function automatic logic [SUM_W-1:0] lane_sum(input logic [WORD_W-1:0] d, input int s);
        logic [SUM_W-1:0] r;
        r = '0;
        for (int i = 0; i < WORD_W; i++)
            if (i < (WORD_W / s) * s && d[i]) r = r + (SUM_W'(1) << (i % s));
        return r;
    endfunction

    // Accumulator bits that belong to a lane at width s.
    function automatic logic [ACC_W-1:0] acc_used(input int s);
        logic [ACC_W-1:0] m;
        m = '0;
        for (int i = 0; i < ACC_W; i++) m[i] = (i < (WORD_W / s) * 2 * s);
        return m;
    endfunction

    logic              s1_valid;
    op_e               s1_op;
    size_e             s1_mode;
    logic [WORD_W-1:0] s1_a, s1_b;
    logic [ACC_W-1:0]  acc_q;

    int                s1_w;
    logic [WORD_W-1:0] add_sum, add_co_unused, abs_d, mul_lo, mac_lo;
    logic [ACC_W-1:0]  prod_w, mac_sum, mac_co_unused, acc_new;
    logic [SUM_W-1:0]  sad_sum;
    logic [WORD_W-1:0] res_d;
    logic [SUM_W-1:0]  sc_d;

    // Stage 1: capture the issue; data only on a valid issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_op    <= OP_ADD;
            s1_mode  <= SZ_8;
            s1_a     <= '0;
            s1_b     <= '0;
        end else begin
            s1_valid <= in_valid_i;
            if (in_valid_i) begin
                s1_op   <= op_e'(op_i);
                s1_mode <= size_e'(mode_i);
                s1_a    <= opa_i;
                s1_b    <= opb_i;
            end
        end
    end

    assign s1_w = lane_bits(s1_mode);

    simd_seg_adder #(.W(WORD_W), .SCALE(1)) u_add (
        .mode(s1_mode), .a(s1_a), .b(s1_b), .cin(1'b0),
        .sum(add_sum), .lane_co(add_co_unused)
    );

    simd_lane_absdiff #(.W(WORD_W)) u_abs (
        .mode(s1_mode), .a(s1_a), .b(s1_b), .diff(abs_d)
    );

    simd_lane_mul #(.W(WORD_W)) u_mul (
        .mode(s1_mode), .a(s1_a), .b(s1_b), .prod(prod_w)
    );

    simd_seg_adder #(.W(ACC_W), .SCALE(2)) u_acc_add (
        .mode(s1_mode), .a(acc_q), .b(prod_w), .cin(1'b0),
        .sum(mac_sum), .lane_co(mac_co_unused)
    );

    // Accumulator update: lane bits take the sum, bits above the lanes hold.
    always_comb begin
        logic [ACC_W-1:0] m;
        m       = acc_used(s1_w);
        acc_new = (mac_sum & m) | (acc_q & ~m);
    end

    assign mul_lo  = narrow(prod_w, s1_w);
    assign mac_lo  = narrow(acc_new, s1_w);
    assign sad_sum = lane_sum(abs_d, s1_w);

    // Pick the stage-2 result by opcode.
    always_comb begin
        res_d = '0;
        sc_d  = '0;
        case (s1_op)
            OP_ADD:     res_d = add_sum;
            OP_ABSDIFF: res_d = abs_d;
            OP_MUL:     res_d = mul_lo;
            OP_SAD: begin
                res_d = abs_d;
                sc_d  = sad_sum;
            end
            OP_MAC:     res_d = mac_lo;
            default: begin
                res_d = '0;
                sc_d  = '0;
            end
        endcase
    end

    // Stage 2: register outputs; hold them when nothing is due.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            result_o    <= '0;
            scalar_o    <= '0;
        end else begin
            out_valid_o <= s1_valid;
            if (s1_valid) begin
                result_o <= res_d;
                scalar_o <= sc_d;
            end
        end
    end

    // Accumulator bank: clear first, then a completing multiply-accumulate.
    always_ff @(posedge clk) begin
        if (!rst_n)                         acc_q <= '0;
        else if (acc_clr_i)                 acc_q <= '0;
        else if (s1_valid && s1_op == OP_MAC) acc_q <= acc_new;
    end

    assign acc_o = acc_q;

endmodule

// File: rtl/simd_subword_chk.sv
// Protocol and state checks for simd_subword_unit, observed at its ports.
// A warm-up counter keeps two-cycle history checks out of the reset period.
module simd_subword_chk #(
    parameter  int WORD_W = 48,
    localparam int SUM_W  = 16 + $clog2(WORD_W / 8),
    localparam int ACC_W  = 2 * WORD_W,
    localparam int USED10 = (WORD_W / 10) * 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid_i,
    input logic [1:0]        mode_i,
    input logic [2:0]        op_i,
    input logic              acc_clr_i,
    input logic              out_valid_o,
    input logic [WORD_W-1:0] result_o,
    input logic [SUM_W-1:0]  scalar_o,
    input logic [ACC_W-1:0]  acc_o
);

    logic [1:0] warm_cnt;
    logic       warm;
    logic       prev_low = 1'b0;

    // Count edges since reset, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n)              warm_cnt <= '0;
        else if (warm_cnt != 2'd2) warm_cnt <= warm_cnt + 2'd1;
    end
    assign warm = (warm_cnt == 2'd2);

    // Remember that reset was sampled low at the previous edge.
    always_ff @(posedge clk) begin
        prev_low <= !rst_n;
        if (prev_low) begin
            AST_RESET_CLEARS: assert (!out_valid_o && result_o == '0 && scalar_o == '0 && acc_o == '0); // R1
        end
    end

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (out_valid_o == $past(in_valid_i, 2))); // R2

    AST_SCALAR_ONLY_SAD: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid_o && $past(op_i, 2) != 3'd3) |-> (scalar_o == '0)); // R10

    AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        acc_clr_i |=> (acc_o == '0)); // R8

    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !$past(acc_clr_i) && !($past(in_valid_i, 2) && $past(op_i, 2) == 3'd4))
        |-> $stable(acc_o)); // R7

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid_o && $past(mode_i, 2) == 2'd1) |-> ((result_o >> USED10) == '0)); // R11

endmodule

bind simd_subword_unit simd_subword_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/tb_simd_subword_unit.sv
// Bench: behavioural two-stage model, all outputs compared at every falling edge.
module tb_simd_subword_unit;

    localparam int W  = 48;
    localparam int SW = 16 + $clog2(W / 8);
    localparam int AW = 2 * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    mode = '0;
    logic [2:0]    op = '0;
    logic [W-1:0]  opa = '0, opb = '0;
    logic          acc_clr = 1'b0;
    logic          out_valid;
    logic [W-1:0]  result;
    logic [SW-1:0] scalar;
    logic [AW-1:0] acc;
    string         tag_in = "R1";

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    simd_subword_unit #(.WORD_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .mode_i(mode), .op_i(op),
        .opa_i(opa), .opb_i(opb), .acc_clr_i(acc_clr), .out_valid_o(out_valid),
        .result_o(result), .scalar_o(scalar), .acc_o(acc)
    );

    // Model state.
    logic          m1_valid = 0;
    int            m1_op = 0, m1_mode = 0;
    logic [W-1:0]  m1_a = '0, m1_b = '0;
    string         m1_tag = "R1";
    logic          m_ov = 0;
    logic [W-1:0]  m_res = '0;
    logic [SW-1:0] m_sc = '0;
    logic [AW-1:0] m_acc = '0;
    string         m_tag = "R1", m_acc_tag = "R1";

    task automatic model_op(input int o, input int md, input logic [W-1:0] a, input logic [W-1:0] b,
                            input logic [AW-1:0] acc_in, output logic [W-1:0] res,
                            output logic [SW-1:0] sc, output logic [AW-1:0] acc_out);
        int s, n;
        longint unsigned mk, mk2, x, y, r, old, nw, tot;
        s = (md == 3) ? 16 : 8 + 2 * md;
        n = W / s;
        mk = (64'd1 << s) - 1;
        mk2 = (64'd1 << (2 * s)) - 1;
        res = '0; tot = 0; acc_out = acc_in;
        for (int l = 0; l < n; l++) begin
            x = 64'(a >> (l * s)) & mk;
            y = 64'(b >> (l * s)) & mk;
            case (o)
                0: r = (x + y) & mk;
                1: r = (x > y) ? x - y : y - x;
                2: r = (x * y) & mk;
                3: begin r = (x > y) ? x - y : y - x; tot += r; end
                4: begin
                    old = 64'(acc_in >> (l * 2 * s)) & mk2;
                    nw  = (old + x * y) & mk2;
                    acc_out = acc_out & ~(AW'(mk2) << (l * 2 * s));
                    acc_out = acc_out | (AW'(nw) << (l * 2 * s));
                    r = nw & mk;
                end
                default: r = 0;
            endcase
            res = res | (W'(r) << (l * s));
        end
        sc = SW'(tot);
    endtask

    // Model advance at each rising edge.
    always @(posedge clk) begin
        logic [W-1:0]  r;
        logic [SW-1:0] sc;
        logic [AW-1:0] an, acc_next;
        if (!rst_n) begin
            m1_valid <= 0; m_ov <= 0; m_res <= '0; m_sc <= '0; m_acc <= '0;
            m_tag <= "R1"; m_acc_tag <= "R1";
        end else begin
            m1_valid <= in_valid; m1_op <= int'(op); m1_mode <= int'(mode);
            m1_a <= opa; m1_b <= opb; m1_tag <= tag_in;
            m_ov <= m1_valid;
            acc_next = m_acc;
            if (m1_valid) begin
                model_op(m1_op, m1_mode, m1_a, m1_b, m_acc, r, sc, an);
                m_res <= r; m_sc <= sc; m_tag <= m1_tag;
                if (m1_op == 4) acc_next = an;
            end
            if (acc_clr) begin acc_next = '0; m_acc_tag <= "R8"; end
            else m_acc_tag <= "R7";
            m_acc <= acc_next;
        end
    end

    task automatic check(input string tag, input string what, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check((m_tag == "R1") ? "R1" : "R2", "out_valid", 128'(out_valid), 128'(m_ov));
        check(m_tag, "result", 128'(result), 128'(m_res));
        check((m_tag == "R1") ? "R1" : "R6", "scalar", 128'(scalar), 128'(m_sc));
        check(m_acc_tag, "acc", 128'(acc), 128'(m_acc));
    endtask

    task automatic issue(input logic v, input int o, input int md, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic clr, input string tag);
        @(negedge clk);
        compare_all();
        in_valid = v; op = 3'(o); mode = 2'(md); opa = a; opb = b; acc_clr = clr; tag_in = tag;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) issue(0, 0, 0, '0, '0, 0, "R2");
    endtask

    initial begin
        for (int i = 0; i < 3; i++) issue(1, 0, 0, 48'h123456789ABC, 48'h1, 0, "R1");
        rst_n = 1'b1;
        // R3 add, each width, lane wrap without carry crossing
        issue(1, 0, 0, 48'hFFFFFFFFFFFF, 48'h010101010101, 0, "R3");
        issue(1, 0, 0, 48'h807F01FE1020, 48'h8001FF02F0E0, 0, "R3");
        issue(1, 0, 1, 48'hFFFFFFFFFFFF, 48'h000040100401, 0, "R11");
        issue(1, 0, 2, 48'hFFF8007FF001, 48'h001800001FFF, 0, "R3");
        issue(1, 0, 3, 48'hFFFF80001234, 48'h00018000EDCC, 0, "R3");
        // R4 absolute difference, both orders
        issue(1, 1, 0, 48'h00FF1020807F, 48'hFF002010_7F80, 0, "R4");
        issue(1, 1, 1, 48'hAB_3FF00001F, 48'h00_0013FF2E0, 0, "R4");
        issue(1, 1, 2, 48'h000FFF123800, 48'hFFF000321801, 0, "R4");
        issue(1, 1, 3, 48'h0000FFFF7FFF, 48'hFFFF00008000, 0, "R4");
        // R5 multiply low bits
        issue(1, 2, 0, 48'hFFFFFFFFFFFF, 48'hFFFFFFFFFFFF, 0, "R5");
        issue(1, 2, 2, 48'hABC123FFF002, 48'h00F456FFF800, 0, "R5");
        issue(1, 2, 3, 48'hFFFF00FF1234, 48'hFFFF01005678, 0, "R5");
        issue(1, 2, 1, 48'hFF_3FF3FF3FF, 48'h00_3FF001002, 0, "R5");
        // R6 SAD at maximum and mixed values
        issue(1, 3, 0, 48'hFFFFFFFFFFFF, 48'h0, 0, "R6");
        issue(1, 3, 1, 48'hFFFFFFFFFFFF, 48'h0, 0, "R6");
        issue(1, 3, 2, 48'h0, 48'hFFFFFFFFFFFF, 0, "R6");
        issue(1, 3, 3, 48'hFFFFFFFFFFFF, 48'h0, 0, "R6");
        issue(1, 3, 0, 48'h10F020E03040, 48'hF010E0204030, 0, "R6");
        idle(2);
        // R7 multiply-accumulate wraps at double width; R8 clear
        issue(0, 0, 0, '0, '0, 1, "R8");
        issue(1, 4, 0, 48'hFFFFFFFFFFFF, 48'hFFFFFFFFFFFF, 0, "R7");
        issue(1, 4, 0, 48'hFFFFFFFFFFFF, 48'hFFFFFFFFFFFF, 0, "R7");
        issue(1, 4, 0, 48'h0102030405FF, 48'h0A0B0C0D0E02, 0, "R7");
        idle(2);
        issue(1, 4, 3, 48'hFFFF12340001, 48'hFFFF00100002, 0, "R7");
        issue(0, 0, 0, '0, '0, 1, "R8");
        issue(1, 4, 1, 48'hFFFFFFFFFFFF, 48'h00FF_FFFFFFFF, 0, "R7");
        idle(2);
        issue(1, 4, 2, 48'hFFFFFFFFFFFF, 48'hFFFFFFFFFFFF, 0, "R7");
        issue(1, 4, 2, 48'hFFFFFFFFFFFF, 48'hFFFFFFFFFFFF, 0, "R7");
        idle(2);
        // R10 unsupported opcodes leave the accumulator alone
        issue(1, 5, 0, 48'h123456789ABC, 48'h1, 0, "R10");
        issue(1, 6, 2, 48'hFFFFFFFFFFFF, 48'h1, 0, "R10");
        issue(1, 7, 3, 48'hFFFFFFFFFFFF, 48'hFFFFFFFFFFFF, 0, "R10");
        idle(2);
        // R9 width and opcode change on every issue
        for (int i = 0; i < 300; i++) begin
            issue(($urandom % 4) != 0, int'($urandom % 8), int'($urandom % 4),
                  W'({$urandom, $urandom}), W'({$urandom, $urandom}), ($urandom % 16) == 0, "R9");
        end
        idle(3);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule